// File: doc/BRIEF.md
# Auto-Incrementing Palette Register Bank

This block holds the colour state of a video controller: a 256-entry colour lookup table, one border colour and three cursor colours. Software writes it through a single 32-bit write port. Each word carries its own target: bits [31:24] select the register and bits [23:0] carry the 24-bit colour value. The lookup table is loaded as a stream. A write to the index selector moves an internal write pointer back to entry 0. Each later write to the data selector fills the entry under the pointer and then advances the pointer. The pointer is 8 bits wide and wraps from 255 to 0.

The display path reads colours through a pixel port. It presents an 8-bit pixel index and gets the matching entry one clock later. A separate shadow port returns any stored register combinationally, including the write pointer, so that software can read the complete state back and restore it. A write whose selector matches no register changes nothing and raises an error flag for one cycle.

Write decoding is a small set of named commands: NONE, PAL_INDEX, PAL_DATA, BORDER, CURSOR1, CURSOR2, CURSOR3 and BAD. The error flag is driven by a two-state machine:
- CLEAN goes to FAULT on a write that decodes as BAD.
- FAULT goes back to CLEAN on any cycle without a BAD write.
- FAULT stays in FAULT while BAD writes follow one another.

Top module: `pal_regbank`

## Requirements
- R1: After reset, every palette entry, the border colour, all three cursor colours and the write pointer read back as 0, and `wr_err` is 0.
- R2: A write with selector 0x10 sets the write pointer to 0 whatever its data bits hold.
- R3: A write with selector 0x00 stores bits [23:0] in the palette entry under the pointer and then increments the pointer by one.
- R4: The write pointer wraps from 255 to 0, so the 257th data write after an index write overwrites entry 0 and leaves the pointer at 1.
- R5: Selectors 0x40, 0x50, 0x60 and 0x70 store bits [23:0] in the border colour and in cursor colours 1, 2 and 3 respectively, and leave the palette and the pointer unchanged.
- R6: A write with any other selector changes no stored state, and `wr_err` is 1 in the clock cycle after it; otherwise `wr_err` is 0.
- R7: `pix_color` shows the palette entry addressed by `pix_idx` at the previous rising clock edge.
- R8: `sh_data` combinationally returns the shadow-port register selected by `sh_addr`:
  - addresses 0 to 255 return palette entries;
  - 256 returns the border colour;
  - 257 to 259 return cursor colours 1 to 3;
  - 260 returns the pointer, zero-extended;
  - every other address returns 0.
- R9: While `wr_en` is 0 the word on `wr_word` has no effect on any stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for `wr_word` |
| wr_word | input | 32 | Selector in [31:24], colour value in [23:0] |
| wr_err | output | 1 | High for one cycle after a write with an unknown selector |
| pix_idx | input | 8 | Pixel index for lookup |
| pix_color | output | 24 | Palette entry for the pixel index, one clock later |
| sh_addr | input | 9 | Shadow register number |
| sh_data | output | 24 | Value of the selected shadow register |

## Verification
The assertions assume that `wr_word` is stable and defined in every cycle where `wr_en` is high. They also assume that reset is applied before the first write. The bench drives all inputs on the falling clock edge from tasks, and it holds `wr_en` low outside a single write cycle. The pixel index never names the entry being written in the same cycle, so the outcome of a read colliding with a write is left untested. Unknown selectors are sent with real data bits present, so a decoder that ignored the selector would show up as a changed register.

// File: rtl/pal_pkg.sv
package pal_pkg;

    localparam int SEL_W = 8;

    localparam logic [SEL_W-1:0] SEL_PAL_INDEX = 8'h10;
    localparam logic [SEL_W-1:0] SEL_PAL_DATA  = 8'h00;
    localparam logic [SEL_W-1:0] SEL_BORDER    = 8'h40;
    localparam logic [SEL_W-1:0] SEL_CURSOR1   = 8'h50;
    localparam logic [SEL_W-1:0] SEL_CURSOR2   = 8'h60;
    localparam logic [SEL_W-1:0] SEL_CURSOR3   = 8'h70;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_PAL_INDEX,
        CMD_PAL_DATA,
        CMD_BORDER,
        CMD_CURSOR1,
        CMD_CURSOR2,
        CMD_CURSOR3,
        CMD_BAD
    } cmd_e;

    typedef enum logic {
        ST_CLEAN,
        ST_FAULT
    } err_state_e;

    // Colour register slot 0 is the border, slots 1..3 are cursors.
    function automatic cmd_e colour_cmd(input int slot);
        case (slot)
            0:       return CMD_BORDER;
            1:       return CMD_CURSOR1;
            2:       return CMD_CURSOR2;
            default: return CMD_CURSOR3;
        endcase
    endfunction

endpackage

// File: rtl/pal_decode.sv
module pal_decode
    import pal_pkg::*;
(
    input  logic             wr_en,
    input  logic [SEL_W-1:0] sel,
    output cmd_e             cmd
);

    always_comb begin
        cmd = CMD_NONE;
        if (wr_en) begin
            unique case (sel)
                SEL_PAL_INDEX: cmd = CMD_PAL_INDEX;
                SEL_PAL_DATA:  cmd = CMD_PAL_DATA;
                SEL_BORDER:    cmd = CMD_BORDER;
                SEL_CURSOR1:   cmd = CMD_CURSOR1;
                SEL_CURSOR2:   cmd = CMD_CURSOR2;
                SEL_CURSOR3:   cmd = CMD_CURSOR3;
                default:       cmd = CMD_BAD;
            endcase
        end
    end

endmodule

// File: rtl/pal_ptr.sv
module pal_ptr
    import pal_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_e             cmd,
    output logic [PTR_W-1:0] wptr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
        end else begin
            unique case (cmd)
                CMD_PAL_INDEX: wptr <= '0;
                CMD_PAL_DATA:  wptr <= wptr + 1'b1;
                default:       wptr <= wptr;
            endcase
        end
    end

    AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_PAL_INDEX |=> wptr == '0); // R2

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_PAL_DATA |=> wptr == PTR_W'($past(wptr) + 1)); // R4

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_PAL_DATA && cmd != CMD_PAL_INDEX) |=> $stable(wptr)); // R5

endmodule

// File: rtl/pal_store.sv
module pal_store
    import pal_pkg::*;
#(
    parameter int COL_W = 24,
    parameter int DEPTH = 256,
    parameter int PTR_W = 8,
    parameter int SH_AW = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_e             cmd,
    input  logic [COL_W-1:0] wdata,
    input  logic [PTR_W-1:0] wptr,
    input  logic [PTR_W-1:0] pix_idx,
    output logic [COL_W-1:0] pix_color,
    input  logic [SH_AW-1:0] sh_addr,
    output logic [COL_W-1:0] sh_data
);

    localparam int NCOL = 4;
    localparam logic [SH_AW-1:0] COL_BASE = SH_AW'(DEPTH);
    localparam logic [SH_AW-1:0] PTR_ADDR = SH_AW'(DEPTH + NCOL);

    logic [COL_W-1:0] pal_mem [DEPTH];
    logic [COL_W-1:0] colour  [NCOL];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) pal_mem[i] <= '0;
            pix_color <= '0;
        end else begin
            if (cmd == CMD_PAL_DATA) pal_mem[wptr] <= wdata;
            pix_color <= pal_mem[pix_idx];
        end
    end

    for (genvar g = 0; g < NCOL; g++) begin : g_colour
        localparam cmd_e MY_CMD = colour_cmd(g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             colour[g] <= '0;
            else if (cmd == MY_CMD) colour[g] <= wdata;
        end
    end

    always_comb begin
        sh_data = '0;
        if (sh_addr < COL_BASE)
            sh_data = pal_mem[sh_addr[PTR_W-1:0]];
        else if (sh_addr < PTR_ADDR)
            sh_data = colour[2'(sh_addr - COL_BASE)];
        else if (sh_addr == PTR_ADDR)
            sh_data = COL_W'(wptr);
    end

    AST_COLOUR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_BAD || cmd == CMD_NONE) |=> $stable(colour[0]) && $stable(colour[1])); // R6

endmodule

// File: rtl/pal_regbank.sv
module pal_regbank
    import pal_pkg::*;
#(
    parameter int COL_W = 24,
    parameter int DEPTH = 256,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int SH_AW = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [31:0]      wr_word,
    output logic             wr_err,
    input  logic [PTR_W-1:0] pix_idx,
    output logic [COL_W-1:0] pix_color,
    input  logic [SH_AW-1:0] sh_addr,
    output logic [COL_W-1:0] sh_data
);

    cmd_e             cmd;
    logic [PTR_W-1:0] wptr;
    err_state_e       state, state_nx;

    pal_decode u_decode (
        .wr_en (wr_en),
        .sel   (wr_word[31:24]),
        .cmd   (cmd)
    );

    pal_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd),
        .wptr  (wptr)
    );

    pal_store #(
        .COL_W (COL_W),
        .DEPTH (DEPTH),
        .PTR_W (PTR_W),
        .SH_AW (SH_AW)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .wdata     (wr_word[COL_W-1:0]),
        .wptr      (wptr),
        .pix_idx   (pix_idx),
        .pix_color (pix_color),
        .sh_addr   (sh_addr),
        .sh_data   (sh_data)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_CLEAN: if (cmd == CMD_BAD) state_nx = ST_FAULT;
            ST_FAULT: if (cmd != CMD_BAD) state_nx = ST_CLEAN;
            default:  state_nx = ST_CLEAN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_CLEAN;
        else        state <= state_nx;
    end

    always_comb begin
        wr_err = 1'b0;
        unique case (state)
            ST_CLEAN: wr_err = 1'b0;
            ST_FAULT: wr_err = 1'b1;
            default:  wr_err = 1'b0;
        endcase
    end

    logic sel_known;
    assign sel_known = wr_word[31:24] inside {SEL_PAL_INDEX, SEL_PAL_DATA, SEL_BORDER,
                                              SEL_CURSOR1, SEL_CURSOR2, SEL_CURSOR3};

    AST_ERR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sel_known) |=> wr_err); // R6

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !wr_err); // R9

endmodule

// File: tb/pal_regbank_test.sv
module pal_regbank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_word = '0;
    logic        wr_err;
    logic [7:0]  pix_idx = '0;
    logic [23:0] pix_color;
    logic [8:0]  sh_addr = '0;
    logic [23:0] sh_data;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pal_regbank uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_word   (wr_word),
        .wr_err    (wr_err),
        .pix_idx   (pix_idx),
        .pix_color (pix_color),
        .sh_addr   (sh_addr),
        .sh_data   (sh_data)
    );

    // {write word, shadow address, expected value, requirement number}
    localparam int NV = 13;
    localparam logic [72:0] VEC [NV] = '{
        {32'h10_000000, 9'd260, 24'h000000, 8'd2},  // R2 index write
        {32'h00_112233, 9'd0,   24'h112233, 8'd3},  // R3 first entry
        {32'h00_445566, 9'd1,   24'h445566, 8'd3},  // R3 second entry
        {32'h00_778899, 9'd260, 24'h000003, 8'd3},  // R3 pointer advanced
        {32'hAB_FFFFFF, 9'd260, 24'h000003, 8'd6},  // R6 unknown selector
        {32'h40_0A0B0C, 9'd256, 24'h0A0B0C, 8'd5},  // R5 border
        {32'h50_111111, 9'd257, 24'h111111, 8'd5},  // R5 cursor 1
        {32'h60_222222, 9'd258, 24'h222222, 8'd5},  // R5 cursor 2
        {32'h70_333333, 9'd259, 24'h333333, 8'd5},  // R5 cursor 3
        {32'h70_444444, 9'd260, 24'h000003, 8'd5},  // R5 pointer untouched
        {32'h10_00FFFF, 9'd260, 24'h000000, 8'd2},  // R2 data bits ignored
        {32'h00_ABCDEF, 9'd0,   24'hABCDEF, 8'd3},  // R3 refill entry 0
        {32'h40_555555, 9'd300, 24'h000000, 8'd8}   // R8 unmapped address
    };

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [31:0] w);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_word = w;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic shadow(input logic [8:0] a, output logic [23:0] v);
        sh_addr = a;
        #1;
        v = sh_data;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [23:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 wr_err", 24'(wr_err), 24'h0);
        shadow(9'd260, v); check("R1 pointer", v, 24'h0);
        shadow(9'd256, v); check("R1 border", v, 24'h0);
        shadow(9'd259, v); check("R1 cursor3", v, 24'h0);
        shadow(9'd77, v);  check("R1 palette", v, 24'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            write_word(VEC[i][72:41]);
            shadow(VEC[i][40:32], v);
            check($sformatf("R%0d vector %0d", VEC[i][7:0], i), v, VEC[i][31:8]);
        end

        // R6 error flag timing
        @(negedge clk);
        wr_en = 1'b1; wr_word = 32'h20_123456;
        @(negedge clk);
        check("R6 flag raised", 24'(wr_err), 24'h1);
        wr_word = 32'h40_010203;
        @(negedge clk);
        wr_en = 1'b0;
        check("R6 flag cleared", 24'(wr_err), 24'h0);
        shadow(9'd256, v); check("R6 good write after bad", v, 24'h010203);

        // R9 strobe low
        @(negedge clk);
        wr_word = 32'h40_DEAD00;
        @(negedge clk);
        @(negedge clk);
        shadow(9'd256, v); check("R9 border unchanged", v, 24'h010203);
        shadow(9'd260, v); check("R9 pointer unchanged", v, 24'h1);

        // R4 wrap
        write_word(32'h10_000000);
        for (int k = 0; k < 256; k++) write_word({8'h00, 24'(k * 3 + 7)});
        shadow(9'd260, v); check("R4 pointer wrapped", v, 24'h0);
        shadow(9'd255, v); check("R4 last entry", v, 24'(255 * 3 + 7));
        write_word(32'h00_FFFFFF);
        shadow(9'd0, v);   check("R4 entry 0 overwritten", v, 24'hFFFFFF);
        shadow(9'd1, v);   check("R4 entry 1 kept", v, 24'(1 * 3 + 7));
        shadow(9'd260, v); check("R4 pointer at 1", v, 24'h1);

        // R7 pixel port latency
        @(negedge clk);
        pix_idx = 8'd5;
        @(negedge clk);
        check("R7 pixel 5", pix_color, 24'(5 * 3 + 7));
        pix_idx = 8'd200;
        @(posedge clk);
        #1;
        check("R7 one clock later", pix_color, 24'(200 * 3 + 7));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule